// File: doc/BRIEF.md
# Serial Avionics Word Transmitter

This block turns parallel words from a host into a serial, return-to-zero stream on two logic-level lines, one that pulses for a one and one that pulses for a zero. The host writes up to eight words into an internal buffer with a write strobe, normally while the transmit enable is low. When the enable goes high, the buffered words are sent in the order they were written. Consecutive words are always separated by a fixed null gap of four bit times. A ready flag tells the host that the buffer is empty and no word is on the line. The block has no bit clock of its own. An external strobe, `half_tick`, pulses once for every half bit, and every timing step follows it.

A small configuration register selects the word length (full 32-bit or reduced 25-bit), the parity sense (odd for normal use, even for testing a receiver's parity check), whether the final bit of a 25-bit word carries data instead of parity, and a loopback mode. In loopback mode the stream goes to a separate pair of outputs and the line outputs stay quiet. The master reset is asynchronous and active low. It clears the buffer, the configuration and the sequencer, so the lines stay low from power-up until the first word is launched.

The sequencer has four named states. `ST_IDLE` waits for a word. `ST_MARK` is the first half of a bit, when one line is high. `ST_SPACE` is the second half, when both lines are low. `ST_GAP` counts out the null halves between words. The transitions, each taken on a `half_tick`, are:
- launch: `ST_IDLE` to `ST_MARK`, when enable is high and the buffer is not empty.
- half: `ST_MARK` to `ST_SPACE`.
- next bit: `ST_SPACE` to `ST_MARK`.
- word end: `ST_SPACE` to `ST_GAP`.
- relaunch: `ST_GAP` to `ST_MARK`, when the gap is complete and another word is waiting and enabled.
- rest: `ST_GAP` to `ST_IDLE`, when the gap is complete and no word is ready to go.

Top module: `avx_word_tx`

## Requirements
- R1: While reset is low, and right after it is released, all four stream outputs are low, `tx_ready` is 1 and `ovf` is 0. The configuration clears to odd parity, 32-bit words and loopback off.
- R2: Each bit lasts two `half_tick` periods. In the first period, a 1 raises `line_hi` only and a 0 raises `line_lo` only. In the second period both lines are low. The two lines are never high together.
- R3: A 32-bit word goes out in this order: `wr_word[7]` down to `wr_word[0]`, then `wr_word[8]` up to `wr_word[30]`, then the parity bit last.
- R4: With `cfg_in[0]`=0, parity makes the number of ones across all sent bits odd. With `cfg_in[0]`=1, it makes that number even.
- R5: With `cfg_in[1]`=1, a word is 25 bits. It goes out as `wr_word[7]` down to `wr_word[0]`, then `wr_word[8]` up to `wr_word[23]`, then a parity bit computed over those 24 bits.
- R6: With `cfg_in[1]`=1 and `cfg_in[2]`=1, the 25th bit sent is `wr_word[24]` instead of parity.
- R7: Between back-to-back words, both lines stay low for exactly 4 bit times (8 `half_tick` periods). A 32-bit word therefore takes 36 bit times and a 25-bit word takes 29.
- R8: The buffer holds 8 words and sends them first-in, first-out.
- R9: While `tx_enable` is low, no new word starts and buffered words are kept. A word already in progress when enable falls is finished.
- R10: `tx_ready` is high exactly when the buffer is empty and no word's bits are being sent. It is low while a word is on the line.
- R11: A write to a full buffer is dropped and sets `ovf`, which stays set until reset.
- R12: With `cfg_in[3]`=1, the stream appears on `loop_hi`/`loop_lo` and `line_hi`/`line_lo` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| half_tick | input | 1 | One-cycle strobe, one per half bit |
| cfg_wr | input | 1 | Loads `cfg_in` into the configuration register |
| cfg_in | input | 4 | [0] even parity, [1] 25-bit word, [2] last bit is data, [3] loopback |
| wr_en | input | 1 | Write strobe for the word buffer |
| wr_word | input | 32 | Word to buffer |
| tx_enable | input | 1 | Allows words to be launched |
| line_hi | output | 1 | Line output that pulses for a one |
| line_lo | output | 1 | Line output that pulses for a zero |
| loop_hi | output | 1 | Loopback output that pulses for a one |
| loop_lo | output | 1 | Loopback output that pulses for a zero |
| tx_ready | output | 1 | Buffer empty and no word in progress |
| ovf | output | 1 | Sticky flag for a dropped write |

## Verification
The assertions check, on every cycle, that the two lines of a pair are never high together, that all outputs are quiet during the gap state, that an idle sequencer with enable low stays idle, that the buffer count never exceeds its depth, that the overflow flag is raised and then held, that ready is never high while the buffer has words in it, and that loopback keeps the line pair quiet. Only the bench scenarios can show what the stream actually carries. The bench decodes the waveform half-bit by half-bit and compares the decoded bits with the label ordering and parity it computes itself. It does this across the 32-bit, 25-bit and data-bit modes with both parity senses, and it also measures the exact gap length, the first-in, first-out order across a full buffer, and a word that finishes after enable is dropped partway through it.

// File: rtl/avx_tx_pkg.sv
package avx_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2,
        ST_GAP   = 2'd3
    } tx_state_t;

    // Packed so that parity_even sits at bit 0 of the configuration input.
    typedef struct packed {
        logic loopback;
        logic par_as_data;
        logic short_word;
        logic parity_even;
    } tx_cfg_t;

    localparam int unsigned LABEL_BITS = 8;
    localparam int unsigned SHORT_BITS = 25;

endpackage

// File: rtl/avx_tx_fifo.sv
module avx_tx_fifo #(
    parameter  int WIDTH = 32,
    parameter  int DEPTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count,
    output logic             overflow
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/avx_tx_format.sv
module avx_tx_format
    import avx_tx_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int IW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word,
    input  tx_cfg_t          cfg,
    output logic [WIDTH-1:0] frame,
    output logic [IW-1:0]    last_idx
);

    // frame[0] is sent first; the label is mirrored so its top bit leads.
    logic [WIDTH-1:0] mirrored;
    logic [WIDTH-1:0] par_mask;
    logic             ones_odd;
    logic             par_bit;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_order
            if (g < int'(LABEL_BITS)) begin : g_label
                assign mirrored[g] = word[LABEL_BITS - 1 - g];
            end else begin : g_body
                assign mirrored[g] = word[g];
            end
        end
    endgenerate

    always_comb begin
        par_mask = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (cfg.short_word) begin
                par_mask[i] = (i < int'(SHORT_BITS) - 1);
            end else begin
                par_mask[i] = (i < WIDTH - 1);
            end
        end
        ones_odd = ^(word & par_mask);
        par_bit  = cfg.parity_even ? ones_odd : ~ones_odd;

        frame = mirrored;
        if (cfg.short_word) begin
            for (int i = int'(SHORT_BITS); i < WIDTH; i++) begin
                frame[i] = 1'b0;
            end
            frame[SHORT_BITS-1] = cfg.par_as_data ? word[SHORT_BITS-1] : par_bit;
            last_idx = IW'(SHORT_BITS - 1);
        end else begin
            frame[WIDTH-1] = par_bit;
            last_idx = IW'(WIDTH - 1);
        end
    end

endmodule

// File: rtl/avx_tx_seq.sv
module avx_tx_seq
    import avx_tx_pkg::*;
#(
    parameter  int WIDTH      = 32,
    parameter  int GAP_HALVES = 8,
    localparam int IW         = $clog2(WIDTH),
    localparam int GW         = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             enable,
    input  logic             avail,
    input  logic [WIDTH-1:0] frame,
    input  logic [IW-1:0]    last_idx,
    output logic             pop,
    output logic             mark_hi,
    output logic             mark_lo,
    output logic             busy,
    output tx_state_t        state
);

    tx_state_t        state_n;
    logic [WIDTH-1:0] shreg, shreg_n;
    logic [IW-1:0]    bit_idx, idx_n;
    logic [IW-1:0]    last_q, last_n;
    logic [GW-1:0]    gap_cnt, gap_n;
    logic             may_launch;

    assign may_launch = enable && avail;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            last_q  <= '0;
            gap_cnt <= '0;
        end else begin
            state   <= state_n;
            shreg   <= shreg_n;
            bit_idx <= idx_n;
            last_q  <= last_n;
            gap_cnt <= gap_n;
        end
    end

    // Next-state process.
    always_comb begin
        state_n = state;
        shreg_n = shreg;
        idx_n   = bit_idx;
        last_n  = last_q;
        gap_n   = gap_cnt;
        pop     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (half_tick && may_launch) begin
                    pop     = 1'b1;
                    state_n = ST_MARK;
                    shreg_n = frame;
                    idx_n   = '0;
                    last_n  = last_idx;
                end
            end
            ST_MARK: begin
                if (half_tick) begin
                    state_n = ST_SPACE;
                end
            end
            ST_SPACE: begin
                if (half_tick) begin
                    if (bit_idx == last_q) begin
                        state_n = ST_GAP;
                        gap_n   = '0;
                    end else begin
                        state_n = ST_MARK;
                        shreg_n = shreg >> 1;
                        idx_n   = bit_idx + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (half_tick) begin
                    if (gap_cnt == GW'(GAP_HALVES - 1)) begin
                        if (may_launch) begin
                            pop     = 1'b1;
                            state_n = ST_MARK;
                            shreg_n = frame;
                            idx_n   = '0;
                            last_n  = last_idx;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end else begin
                        gap_n = gap_cnt + 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        mark_hi = 1'b0;
        mark_lo = 1'b0;
        busy    = 1'b0;
        unique case (state)
            ST_MARK: begin
                mark_hi = shreg[0];
                mark_lo = !shreg[0];
                busy    = 1'b1;
            end
            ST_SPACE: busy = 1'b1;
            default: begin
                mark_hi = 1'b0;
                mark_lo = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/avx_word_tx.sv
module avx_word_tx
    import avx_tx_pkg::*;
#(
    parameter  int WORD_W   = 32,
    parameter  int DEPTH    = 8,
    parameter  int GAP_BITS = 4,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int IW       = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_in,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              tx_enable,
    output logic              line_hi,
    output logic              line_lo,
    output logic              loop_hi,
    output logic              loop_lo,
    output logic              tx_ready,
    output logic              ovf
);

    tx_cfg_t           cfg_q;
    logic [WORD_W-1:0] head;
    logic              empty;
    logic              full;
    logic [CW-1:0]     fifo_count;
    logic              pop;
    logic [WORD_W-1:0] frame;
    logic [IW-1:0]     last_idx;
    logic              mark_hi;
    logic              mark_lo;
    logic              busy;
    tx_state_t         seq_state;
    logic              loop_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= tx_cfg_t'(cfg_in);
        end
    end

    avx_tx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_en),
        .push_data(wr_word),
        .pop      (pop),
        .head     (head),
        .empty    (empty),
        .full     (full),
        .count    (fifo_count),
        .overflow (ovf)
    );

    avx_tx_format #(.WIDTH(WORD_W)) u_format (
        .word    (head),
        .cfg     (cfg_q),
        .frame   (frame),
        .last_idx(last_idx)
    );

    avx_tx_seq #(.WIDTH(WORD_W), .GAP_HALVES(2 * GAP_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_tick(half_tick),
        .enable   (tx_enable),
        .avail    (!empty),
        .frame    (frame),
        .last_idx (last_idx),
        .pop      (pop),
        .mark_hi  (mark_hi),
        .mark_lo  (mark_lo),
        .busy     (busy),
        .state    (seq_state)
    );

    assign loop_sel = cfg_q.loopback;
    assign line_hi  = mark_hi && !loop_sel;
    assign line_lo  = mark_lo && !loop_sel;
    assign loop_hi  = mark_hi && loop_sel;
    assign loop_lo  = mark_lo && loop_sel;
    assign tx_ready = empty && !busy;

endmodule

// File: rtl/avx_word_tx_chk.sv
module avx_word_tx_chk
    import avx_tx_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic      clk,
    input logic      rst_n,
    input logic      tx_enable,
    input logic      wr_en,
    input logic      line_hi,
    input logic      line_lo,
    input logic      loop_hi,
    input logic      loop_lo,
    input logic      tx_ready,
    input logic      ovf,
    input logic      loop_sel,
    input tx_state_t state,
    input logic [CW-1:0] fifo_count
);

    assert_rz_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo) && !(loop_hi && loop_lo));

    assert_gap_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (!line_hi && !line_lo && !loop_hi && !loop_lo));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !tx_enable) |=> (state == ST_IDLE));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    assert_full_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_count == CW'(DEPTH)) |=> ovf);

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    assert_ready_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (fifo_count == '0));

    assert_loop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        loop_sel |-> (!line_hi && !line_lo));

endmodule

bind avx_word_tx avx_word_tx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .wr_en     (wr_en),
    .line_hi   (line_hi),
    .line_lo   (line_lo),
    .loop_hi   (loop_hi),
    .loop_lo   (loop_lo),
    .tx_ready  (tx_ready),
    .ovf       (ovf),
    .loop_sel  (loop_sel),
    .state     (seq_state),
    .fifo_count(fifo_count)
);

// File: tb/avx_word_tx_tb_top.sv
`timescale 1ns/1ps
module avx_word_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_tick;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_in = 4'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic        tx_enable = 1'b0;
    logic        line_hi, line_lo, loop_hi, loop_lo, tx_ready, ovf;

    int errors = 0;
    int checks = 0;
    logic [1:0] tc = 2'd0;

    always #5 clk = ~clk;

    always @(posedge clk) tc <= tc + 2'd1;
    assign half_tick = (tc == 2'd3);

    avx_word_tx dut_i (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .cfg_wr(cfg_wr), .cfg_in(cfg_in), .wr_en(wr_en), .wr_word(wr_word),
        .tx_enable(tx_enable), .line_hi(line_hi), .line_lo(line_lo),
        .loop_hi(loop_hi), .loop_lo(loop_lo), .tx_ready(tx_ready), .ovf(ovf)
    );

    // Half-bit decoder, sampling in the middle of each half period.
    logic        sel_loop = 1'b0;
    int          exp_len = 32;
    logic [31:0] rx_w[$];
    int          rx_gap[$];
    logic [31:0] cur = '0;
    int          bits_n = 0;
    int          null_cnt = 0;
    int          null_before = 0;
    bit          in_word = 0;
    bit          expect_space = 0;
    int          rz_bad = 0;
    bit          main_act = 0;

    always @(negedge clk) begin
        if (rst_n && tc == 2'd1) begin
            logic h, l;
            h = sel_loop ? loop_hi : line_hi;
            l = sel_loop ? loop_lo : line_lo;
            if (sel_loop && (line_hi || line_lo)) main_act = 1;
            if (expect_space) begin
                if (h || l) rz_bad++;
                expect_space = 0;
                if (bits_n == exp_len) begin
                    rx_w.push_back(cur);
                    rx_gap.push_back(null_before);
                    in_word = 0;
                    null_cnt = 0;
                end
            end else if (h || l) begin
                if (h && l) rz_bad++;
                if (!in_word) begin
                    in_word = 1;
                    null_before = null_cnt;
                    bits_n = 0;
                    cur = '0;
                end
                cur[bits_n] = h;
                bits_n++;
                expect_space = 1;
            end else begin
                null_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic [31:0] w, input logic [3:0] c);
        logic [31:0] f;
        int last, ones;
        f = '0;
        last = c[1] ? 24 : 31;
        ones = 0;
        for (int i = 0; i < last; i++) ones += w[i];
        for (int i = 0; i < 8; i++) f[i] = w[7 - i];
        for (int i = 8; i < last; i++) f[i] = w[i];
        if (c[1] && c[2]) f[last] = w[24];
        else if (c[0]) f[last] = ones[0];
        else f[last] = ~ones[0];
        return f;
    endfunction

    function automatic logic [31:0] gen_word(input int k);
        if (k == 0) return 32'h0000_0000;
        if (k == 1) return 32'hFFFF_FFFF;
        return (32'h9E37_79B9 * k) ^ (k << 7) ^ 32'h0100_0000 * k;
    endfunction

    task automatic wait_halves(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (tc != 2'd1) @(negedge clk);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [3:0] c);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_in = c;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        int g = 0;
        while (rx_w.size() < n && g < 20000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic run_batch(input logic [3:0] c, input int n, input int seed, input string req);
        logic [31:0] words[8];
        set_cfg(c);
        exp_len = c[1] ? 25 : 32;
        sel_loop = c[3];
        rx_w.delete();
        rx_gap.delete();
        for (int k = 0; k < n; k++) begin
            words[k] = gen_word(seed + k);
            push(words[k]);
        end
        wait_halves(20);
        chk(rx_w.size() == 0, "R9 held while disabled", rx_w.size(), 0);
        tx_enable = 1'b1;
        wait_halves(4);
        chk(tx_ready == 1'b0, "R10 ready low while sending", tx_ready, 0);
        wait_rx(n);
        tx_enable = 1'b0;
        chk(rx_w.size() == n, {req, " word count"}, rx_w.size(), n);
        for (int k = 0; k < n && k < rx_w.size(); k++) begin
            chk(rx_w[k] == exp_frame(words[k], c), req, rx_w[k], exp_frame(words[k], c));
            if (k > 0) chk(rx_gap[k] == 8, "R7 gap halves", rx_gap[k], 8);
        end
        wait_halves(2);
        chk(tx_ready == 1'b1, "R10 ready after drain", tx_ready, 1);
        chk(rz_bad == 0, "R2 return to zero", rz_bad, 0);
        wait_halves(10);
    endtask

    initial begin
        #(10 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({line_hi, line_lo, loop_hi, loop_lo} == 4'b0, "R1 lines low in reset",
            {line_hi, line_lo, loop_hi, loop_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1 && ovf == 1'b0, "R1 flags after reset", {tx_ready, ovf}, 2'b10);

        // R1: default configuration is 32-bit odd parity without any cfg write.
        exp_len = 32;
        push(32'hA5C3_0F81);
        tx_enable = 1'b1;
        wait_rx(1);
        tx_enable = 1'b0;
        chk(rx_w.size() == 1 && rx_w[0] == exp_frame(32'hA5C3_0F81, 4'b0000),
            "R1 R3 default format", rx_w.size() > 0 ? rx_w[0] : 32'hx, exp_frame(32'hA5C3_0F81, 4'b0000));
        wait_halves(12);

        run_batch(4'b0000, 8, 0,  "R3 R4 32-bit odd");
        run_batch(4'b0001, 8, 20, "R4 32-bit even");
        run_batch(4'b0010, 8, 40, "R5 25-bit odd");
        run_batch(4'b0011, 8, 60, "R5 25-bit even");
        run_batch(4'b0110, 6, 80, "R6 25-bit data bit");

        // R12: loopback keeps the line pair quiet.
        main_act = 0;
        run_batch(4'b1000, 3, 100, "R12 loopback stream");
        chk(main_act == 0, "R12 line quiet in loopback", main_act, 0);
        sel_loop = 1'b0;

        // R9: drop enable partway through the first word.
        set_cfg(4'b0000);
        exp_len = 32;
        rx_w.delete();
        rx_gap.delete();
        for (int k = 0; k < 3; k++) push(gen_word(120 + k));
        tx_enable = 1'b1;
        while (!in_word) @(negedge clk);
        tx_enable = 1'b0;
        wait_halves(200);
        chk(rx_w.size() == 1, "R9 in-flight word finishes, rest held", rx_w.size(), 1);
        tx_enable = 1'b1;
        wait_rx(3);
        tx_enable = 1'b0;
        for (int k = 0; k < 3 && k < rx_w.size(); k++)
            chk(rx_w[k] == exp_frame(gen_word(120 + k), 4'b0000), "R9 R8 resumed order",
                rx_w[k], exp_frame(gen_word(120 + k), 4'b0000));
        wait_halves(12);

        // R8 R11: nine writes into an eight-deep buffer.
        rx_w.delete();
        rx_gap.delete();
        chk(ovf == 1'b0, "R11 ovf clear before fill", ovf, 0);
        for (int k = 0; k < 9; k++) push(gen_word(200 + k));
        chk(ovf == 1'b1, "R11 ovf on full write", ovf, 1);
        tx_enable = 1'b1;
        wait_rx(8);
        wait_halves(200);
        tx_enable = 1'b0;
        chk(rx_w.size() == 8, "R11 ninth word dropped", rx_w.size(), 8);
        for (int k = 0; k < 8 && k < rx_w.size(); k++)
            chk(rx_w[k] == exp_frame(gen_word(200 + k), 4'b0000), "R8 fifo order",
                rx_w[k], exp_frame(gen_word(200 + k), 4'b0000));
        chk(ovf == 1'b1, "R11 ovf sticky", ovf, 1);

        // R1: reset clears the overflow flag and the configuration.
        set_cfg(4'b0011);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ovf == 1'b0 && tx_ready == 1'b1, "R1 reset clears ovf", {tx_ready, ovf}, 2'b10);
        rx_w.delete();
        exp_len = 32;
        push(32'h1234_5678);
        tx_enable = 1'b1;
        wait_rx(1);
        tx_enable = 1'b0;
        chk(rx_w.size() == 1 && rx_w[0] == exp_frame(32'h1234_5678, 4'b0000), "R1 cfg cleared by reset",
            rx_w.size() > 0 ? rx_w[0] : 32'hx, exp_frame(32'h1234_5678, 4'b0000));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule